// File: doc/BRIEF.md
# Serial DAC Host Frame Generator

This block sits inside a controller and drives a four-wire serial digital-to-analog converter from the system clock. A client hands it an 8-bit output code together with a fast-settling flag and a power-down flag over a valid/ready handshake. The block builds a 16-bit command word and plays it out on a select line, a frame-sync line, a serial clock and a data line. Every minimum interval the converter needs is a parameter counted in system clock cycles.

The sequencer steps in a fixed order. Select goes low, frame-sync follows, and then the serial clock toggles sixteen times, with data sampled on falling edges and changed on rising edges. After a hold time, select and frame-sync return high together. Frame-sync then stays high for a minimum time. Last comes a settling holdoff whose length depends on the selected speed mode, so that a new code is never sent before the analog output has had time to settle. A power-down request needs no settling, so the holdoff is skipped for it. Ready is low from acceptance until all of this has elapsed.

Top module: `dac_frame_host`

## Requirements
- R1: After reset, sel_n, sync_n and sclk are 1, sdo is 0 and req_ready is 1.
- R2: Each frame shifts out 16 bits, most significant first. Bit 15 is 0, bit 14 is req_fast, bit 13 is req_pdown, bit 12 is 0, bits 11..4 are req_code (bit 11 = code bit 7), and bits 3..0 are 0.
- R3: sel_n goes low exactly CS_SETUP cycles before sync_n falls.
- R4: The first falling edge of sclk comes exactly FS_SETUP cycles after sync_n falls, and bit 15 is on sdo from the cycle sync_n falls.
- R5: Within a frame, sclk stays low for exactly SCLK_LO cycles and high for exactly SCLK_HI cycles. sclk falls exactly 16 times per frame, and only while sync_n is low.
- R6: While sync_n is low, sdo changes only in the cycle in which sclk rises.
- R7: sel_n and sync_n rise in the same cycle, exactly CS_HOLD cycles after the 16th rising edge of sclk.
- R8: sync_n stays high for at least FS_HIGH cycles between frames.
- R9: req_ready is low for exactly CS_SETUP+FS_SETUP+16*SCLK_LO+15*SCLK_HI+CS_HOLD+FS_HIGH+H cycles after acceptance. H is SETTLE_FAST when req_fast=1 and SETTLE_SLOW when req_fast=0.
- R10: When req_pdown=1, H is 0 regardless of req_fast.
- R11: A req_valid pulse while req_ready is low starts no frame and does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request valid |
| req_ready | output | 1 | Block idle, request accepted on this cycle |
| req_code | input | 8 | Output code |
| req_fast | input | 1 | 1 selects fast settling |
| req_pdown | input | 1 | 1 requests power-down |
| sel_n | output | 1 | Chip select, active low |
| sync_n | output | 1 | Frame sync, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data to the converter |

## Verification
The scoreboard replays codes at both ends of the range (all zeros, all ones) and alternating patterns, in every combination of the speed and power-down flags. A design that wires the flags or the code into the wrong bit positions, or shifts in the wrong order, produces a mismatched word. Each interval is measured to the exact cycle. An off-by-one in any phase counter, or data that moves on the sampling edge, shows up as a timing mismatch. The ready-low length is measured for fast, slow and power-down frames. Swapping the holdoffs, or keeping a holdoff after power-down, changes that count. A request held valid during a busy frame would, if wrongly accepted, produce an extra unexpected frame.

// File: rtl/dac_host_pkg.sv
package dac_host_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CSSET,
      ST_FSSET,
      ST_LOW,
      ST_HIGH,
      ST_CSHOLD,
      ST_FSHIGH,
      ST_SETTLE
   } host_state_t;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dac_word_pack.sv
module dac_word_pack #(
   parameter int CODE_W  = 8,
   parameter int FRAME_W = 16
) (
   input  logic [CODE_W-1:0]  code,
   input  logic               fast,
   input  logic               pdown,
   output logic [FRAME_W-1:0] word
);
   localparam int PAD_W = FRAME_W - 4 - CODE_W;

   generate
      if (PAD_W > 0) begin : g_pad
         assign word = {1'b0, fast, pdown, 1'b0, code, {PAD_W{1'b0}}};
      end else if (PAD_W == 0) begin : g_nopad
         assign word = {1'b0, fast, pdown, 1'b0, code};
      end else begin : g_bad
         $error("dac_word_pack: code wider than frame allows");
         assign word = '0;
      end
   endgenerate
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/dac_bit_shifter.sv
module dac_bit_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] word,
   input  logic               shift,
   output logic               msb
);
   logic [FRAME_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_q <= '0;
      else if (load)   sh_q <= word;
      else if (shift)  sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
   end

   assign msb = sh_q[FRAME_W-1];
endmodule

// File: rtl/dac_frame_host.sv
module dac_frame_host #(
   parameter int CODE_W      = 8,
   parameter int CS_SETUP    = 2,
   parameter int FS_SETUP    = 1,
   parameter int SCLK_HI     = 4,
   parameter int SCLK_LO     = 4,
   parameter int CS_HOLD     = 2,
   parameter int FS_HIGH     = 3,
   parameter int SETTLE_FAST = 375,
   parameter int SETTLE_SLOW = 1125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CODE_W-1:0] req_code,
   input  logic              req_fast,
   input  logic              req_pdown,
   output logic              sel_n,
   output logic              sync_n,
   output logic              sclk,
   output logic              sdo
);
   import dac_host_pkg::*;

   localparam int FRAME_W = 16;
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam int MAX_PH  = imax(imax(imax(CS_SETUP, FS_SETUP), imax(SCLK_HI, SCLK_LO)),
                                 imax(imax(CS_HOLD, FS_HIGH), imax(SETTLE_FAST, SETTLE_SLOW)));
   localparam int CNT_W   = $clog2(MAX_PH + 1);

   generate
      if (CS_SETUP < 1 || FS_SETUP < 1 || SCLK_HI < 1 || SCLK_LO < 1 ||
          CS_HOLD < 1 || FS_HIGH < 1 || SETTLE_FAST < 1 || SETTLE_SLOW < 1) begin : g_chk_ph
         $error("dac_frame_host: every phase length must be at least one cycle");
      end
      if (CODE_W > 12) begin : g_chk_code
         $error("dac_frame_host: code width exceeds the data field");
      end
   endgenerate

   host_state_t       st_q, st_d;
   logic              ld;
   logic [CNT_W-1:0]  ld_val;
   logic              expired;
   logic              cap, shift;
   logic [BIT_W-1:0]  bit_q;
   logic              fast_q, pdown_q;
   logic [FRAME_W-1:0] word;
   logic              msb;

   dac_word_pack #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_pack (
      .code (req_code), .fast (req_fast), .pdown (req_pdown), .word (word)
   );

   dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk (clk), .rst_n (rst_n), .load (ld), .load_val (ld_val), .expired (expired)
   );

   dac_bit_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk (clk), .rst_n (rst_n), .load (cap), .word (word), .shift (shift), .msb (msb)
   );

   always_comb begin
      st_d   = st_q;
      ld     = 1'b0;
      ld_val = '0;
      cap    = 1'b0;
      shift  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (req_valid) begin
            st_d = ST_CSSET; ld = 1'b1; cap = 1'b1;
            ld_val = CNT_W'(CS_SETUP - 1);
         end
         ST_CSSET: if (expired) begin
            st_d = ST_FSSET; ld = 1'b1; ld_val = CNT_W'(FS_SETUP - 1);
         end
         ST_FSSET: if (expired) begin
            st_d = ST_LOW; ld = 1'b1; ld_val = CNT_W'(SCLK_LO - 1);
         end
         ST_LOW: if (expired) begin
            shift = 1'b1; ld = 1'b1;
            if (bit_q == BIT_W'(FRAME_W - 1)) begin
               st_d = ST_CSHOLD; ld_val = CNT_W'(CS_HOLD - 1);
            end else begin
               st_d = ST_HIGH;   ld_val = CNT_W'(SCLK_HI - 1);
            end
         end
         ST_HIGH: if (expired) begin
            st_d = ST_LOW; ld = 1'b1; ld_val = CNT_W'(SCLK_LO - 1);
         end
         ST_CSHOLD: if (expired) begin
            st_d = ST_FSHIGH; ld = 1'b1; ld_val = CNT_W'(FS_HIGH - 1);
         end
         ST_FSHIGH: if (expired) begin
            if (pdown_q) st_d = ST_IDLE;
            else begin
               st_d = ST_SETTLE; ld = 1'b1;
               ld_val = fast_q ? CNT_W'(SETTLE_FAST - 1) : CNT_W'(SETTLE_SLOW - 1);
            end
         end
         ST_SETTLE: if (expired) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         bit_q   <= '0;
         fast_q  <= 1'b0;
         pdown_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (cap) begin
            bit_q   <= '0;
            fast_q  <= req_fast;
            pdown_q <= req_pdown;
         end else if (shift) begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign sel_n     = (st_q == ST_IDLE) || (st_q == ST_FSHIGH) || (st_q == ST_SETTLE);
   assign sync_n    = !((st_q == ST_FSSET) || (st_q == ST_LOW) ||
                        (st_q == ST_HIGH)  || (st_q == ST_CSHOLD));
   assign sclk      = (st_q != ST_LOW);
   assign sdo       = (st_q == ST_IDLE) ? 1'b0 : msb;
endmodule

// File: rtl/dac_frame_host_chk.sv
module dac_frame_host_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic sel_n,
   input logic sync_n,
   input logic sclk,
   input logic sdo
);
   // R1
   idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sel_n && sync_n && sclk));

   // R3
   sel_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_n) |-> (!sel_n && $past(!sel_n)));

   // R5
   sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> !sync_n);

   // R6
   data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_n && $past(!sync_n) && !$rose(sclk)) |-> $stable(sdo));

   // R7
   frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |-> $rose(sync_n));

   // R11
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

bind dac_frame_host dac_frame_host_chk u_chk (
   .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
   .sel_n (sel_n), .sync_n (sync_n), .sclk (sclk), .sdo (sdo)
);

// File: tb/sim_dac_frame_host.sv
module sim_dac_frame_host;
   localparam int CS_SETUP    = 2;
   localparam int FS_SETUP    = 1;
   localparam int SCLK_HI     = 4;
   localparam int SCLK_LO     = 4;
   localparam int CS_HOLD     = 2;
   localparam int FS_HIGH     = 3;
   localparam int SETTLE_FAST = 375;
   localparam int SETTLE_SLOW = 1125;
   localparam int BASE_BUSY   = CS_SETUP + FS_SETUP + 16*SCLK_LO + 15*SCLK_HI + CS_HOLD + FS_HIGH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [7:0] req_code = '0;
   logic req_fast = 1'b0, req_pdown = 1'b0;
   logic req_ready, sel_n, sync_n, sclk, sdo;

   int checks = 0;
   int errors = 0;
   int frames_seen = 0;
   logic [15:0] exp_q[$];

   always #4 clk = ~clk;

   dac_frame_host #(
      .CODE_W(8), .CS_SETUP(CS_SETUP), .FS_SETUP(FS_SETUP), .SCLK_HI(SCLK_HI),
      .SCLK_LO(SCLK_LO), .CS_HOLD(CS_HOLD), .FS_HIGH(FS_HIGH),
      .SETTLE_FAST(SETTLE_FAST), .SETTLE_SLOW(SETTLE_SLOW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_code(req_code), .req_fast(req_fast), .req_pdown(req_pdown),
      .sel_n(sel_n), .sync_n(sync_n), .sclk(sclk), .sdo(sdo)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   // Monitor: measures every interval and rebuilds the word
   int cyc = 0, t_sel = 0, t_sync = 0, t_fall = 0, t_rise = 0, t_end = -1000;
   int nbits = 0, viol = 0;
   logic [15:0] got;
   logic p_sel = 1'b1, p_sync = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (p_sel && !sel_n) t_sel = cyc;
         if (p_sync && !sync_n) begin
            chk(cyc - t_sel == CS_SETUP, "R3 sel-to-sync", cyc - t_sel, CS_SETUP);
            if (t_end > 0)
               chk(cyc - t_end >= FS_HIGH, "R8 sync high gap", cyc - t_end, FS_HIGH);
            t_sync = cyc; nbits = 0; viol = 0;
         end
         if (!sync_n && !p_sync && sdo != p_sdo && !(sclk && !p_sclk)) viol++;
         if (p_sclk && !sclk) begin
            if (sync_n) chk(1'b0, "R5 sclk fell outside frame", 1, 0);
            else if (nbits == 0)
               chk(cyc - t_sync == FS_SETUP, "R4 sync-to-first-fall", cyc - t_sync, FS_SETUP);
            else
               chk(cyc - t_rise == SCLK_HI, "R5 sclk high", cyc - t_rise, SCLK_HI);
            got = {got[14:0], sdo};
            t_fall = cyc; nbits++;
         end
         if (!p_sclk && sclk) begin
            chk(cyc - t_fall == SCLK_LO, "R5 sclk low", cyc - t_fall, SCLK_LO);
            t_rise = cyc;
         end
         if (!p_sel && sel_n) begin
            chk(sync_n && !p_sync, "R7 sel and sync rise together", int'(sync_n), 1);
            chk(cyc - t_rise == CS_HOLD, "R7 hold after last rise", cyc - t_rise, CS_HOLD);
            chk(nbits == 16, "R5 falls per frame", nbits, 16);
            chk(viol == 0, "R6 sdo moved off rising edge", viol, 0);
            frames_seen++;
            if (exp_q.size() == 0) chk(1'b0, "R11 unexpected frame", int'(got), -1);
            else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk(got == e, "R2 frame word", int'(got), int'(e));
            end
            t_end = cyc;
         end
         p_sel = sel_n; p_sync = sync_n; p_sclk = sclk; p_sdo = sdo;
      end
   end

   // Driver: pushes the expected word and measures the busy window
   task automatic send(input logic [7:0] code, input logic fast, input logic pd,
                       input bit junk);
      int gap;
      int expgap;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      exp_q.push_back({1'b0, fast, pd, 1'b0, code, 4'b0000});
      req_valid = 1'b1; req_code = code; req_fast = fast; req_pdown = pd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      gap = 0;
      while (!req_ready) begin
         gap++;
         if (junk && gap >= 5 && gap < 30) begin
            req_valid = 1'b1; req_code = ~code; req_fast = ~fast; req_pdown = 1'b0;
         end else req_valid = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      expgap = BASE_BUSY + (pd ? 0 : (fast ? SETTLE_FAST : SETTLE_SLOW));
      if (pd) chk(gap == expgap, "R10 power-down busy length", gap, expgap);
      else    chk(gap == expgap, "R9 busy length", gap, expgap);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(sel_n && sync_n && sclk, "R1 idle lines", int'({sel_n, sync_n, sclk}), 7);
      chk(sdo == 1'b0, "R1 idle data", int'(sdo), 0);
      chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

      send(8'h00, 1'b1, 1'b0, 1'b0);
      send(8'hFF, 1'b0, 1'b0, 1'b0);
      send(8'hA5, 1'b1, 1'b1, 1'b0);
      send(8'h5A, 1'b0, 1'b1, 1'b0);
      send(8'h81, 1'b1, 1'b0, 1'b1);   // R11 junk requests while busy
      send(8'h3C, 1'b0, 1'b1, 1'b1);
      send(8'hC3, 1'b0, 1'b0, 1'b0);

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R11 pending expected frames", exp_q.size(), 0);
      chk(frames_seen == 7, "R11 frame count", frames_seen, 7);
      chk(req_ready && sel_n && sync_n, "R1 idle after traffic", int'(req_ready), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule